// File: doc/BRIEF.md
# Six-State Custom Sequence Generator

A clocked synchronous Moore machine that walks a fixed, non-binary loop of six 3-bit codes, taking one step on every rising clock edge. The loop, starting from the reset code, is 011, 111, 001, 010, 100, 110, and then back to 011. The 3-bit state register drives the output directly, with no decoding logic. The output therefore changes only on the clock and never glitches between edges.

Each state bit is held in a J-K style cell. Small excitation equations feed the J and K inputs of each cell. A synchronous, active-high reset has priority over sequencing and loads 011. The two codes outside the loop, 000 and 101, are not reachable in normal use. If the register ever holds one of them, it returns to the loop on the next edge.

Top module: `seq6_gen`

## Requirements
- R1: When `rst` is high at a rising edge, the output becomes 011 after that edge, whatever the current code; reset has priority over sequencing.
- R2: When `rst` is low, each rising edge moves the output to its successor: 011→111, 111→001, 001→010, 010→100, 100→110, 110→011.
- R3: After reset the output returns to 011 after exactly six edges, and the six-code list repeats identically on the following six edges.
- R4: The output bits `code_o[2:0]` are the state register bits; they hold steady between rising edges.
- R5: With the unused code 000 in the register and `rst` low, the next edge gives 010.
- R6: With the unused code 101 in the register and `rst` low, the next edge gives 110.
- R7: From any code, one edge with `rst` low leaves the output on a member of the six-code loop. From then on it follows the loop order.
- R8: The most significant bit `code_o[2]` follows J-K toggle behaviour with J=K=`code_o[1]`: it inverts on an edge when `code_o[1]` was 1 and holds when it was 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to code 011 |
| code_o | output | 3 | Current state code, driven straight from the state register |

## Verification
The output is the state register, so a corrupted state bit appears on `code_o` in the same cycle, with no decoding in between. A wrong J or K term leaves the register correct until the next edge. On that edge it produces a code that breaks the successor order, or the MSB toggle rule when the fault is in that bit. A recovery fault shows up after one edge from an injected 000 or 101, as a code outside the loop or as the wrong entry point.

// File: rtl/seq6_pkg.sv
package seq6_pkg;

    localparam int CODE_W = 3;

    typedef logic [CODE_W-1:0] code_t;

    localparam code_t RESET_CODE = 3'b011;

    typedef struct packed {
        code_t code;
    } seq6_regs_t;

endpackage

// File: rtl/seq6_excite.sv
// Excitation logic: J and K inputs for every state bit, derived from the loop order.
module seq6_excite
    import seq6_pkg::*;
(
    input  code_t cur_i,
    output code_t j_o,
    output code_t k_o
);

    logic q2, q1, q0;

    always_comb begin
        q2 = cur_i[2];
        q1 = cur_i[1];
        q0 = cur_i[0];

        // MSB toggles whenever the middle bit is set
        j_o[2] = q1;
        k_o[2] = q1;

        // Middle bit: always set when low; cleared when Q2 and Q0 agree
        j_o[1] = 1'b1;
        k_o[1] = ~(q2 ^ q0);

        // LSB: set on the way out of 110, cleared when the middle bit is low
        j_o[0] = q2 & q1;
        k_o[0] = ~q1;
    end

endmodule

// File: rtl/seq6_jk_bit.sv
// Next value of one J-K storage bit.
module seq6_jk_bit (
    input  logic q_i,
    input  logic j_i,
    input  logic k_i,
    output logic q_next_o
);

    always_comb begin
        unique case ({j_i, k_i})
            2'b00:   q_next_o = q_i;
            2'b01:   q_next_o = 1'b0;
            2'b10:   q_next_o = 1'b1;
            default: q_next_o = ~q_i;
        endcase
    end

endmodule

// File: rtl/seq6_gen.sv
module seq6_gen
    import seq6_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    output logic [2:0]  code_o
);

    seq6_regs_t regs_d;
    seq6_regs_t regs_q;

    code_t j_vec;
    code_t k_vec;
    code_t step_code;

    seq6_excite u_excite (
        .cur_i (regs_q.code),
        .j_o   (j_vec),
        .k_o   (k_vec)
    );

    for (genvar b = 0; b < CODE_W; b++) begin : g_bit
        seq6_jk_bit u_bit (
            .q_i      (regs_q.code[b]),
            .j_i      (j_vec[b]),
            .k_i      (k_vec[b]),
            .q_next_o (step_code[b])
        );
    end

    always_comb begin
        regs_d = regs_q;
        if (rst) begin
            regs_d.code = RESET_CODE;
        end else begin
            regs_d.code = step_code;
        end
    end

    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

    assign code_o = regs_q.code;

endmodule

// File: rtl/seq6_gen_chk.sv
module seq6_gen_chk
    import seq6_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic [2:0]  code
);

    function automatic logic in_loop(input logic [2:0] c);
        return (c != 3'b000) && (c != 3'b101);
    endfunction

    function automatic logic [2:0] next_in_loop(input logic [2:0] c);
        case (c)
            3'b011:  return 3'b111;
            3'b111:  return 3'b001;
            3'b001:  return 3'b010;
            3'b010:  return 3'b100;
            3'b100:  return 3'b110;
            default: return 3'b011;
        endcase
    endfunction

    logic rst_prev_q;

    always_ff @(posedge clk) begin
        rst_prev_q <= rst;
    end

    // R1
    always @(posedge clk) begin
        if (rst && (rst_prev_q === 1'b1)) begin
            reset_hold_chk: assert (code == RESET_CODE);
        end
    end

    // R2
    succ_order_chk: assert property (@(posedge clk) disable iff (rst)
        (!rst && in_loop(code)) |=> (code == next_in_loop($past(code))));

    // R5
    unused_000_chk: assert property (@(posedge clk) disable iff (rst)
        (!rst && code == 3'b000) |=> (code == 3'b010));

    // R6
    unused_101_chk: assert property (@(posedge clk) disable iff (rst)
        (!rst && code == 3'b101) |=> (code == 3'b110));

    // R7
    settle_chk: assert property (@(posedge clk) disable iff (rst)
        (!rst) |=> in_loop(code));

    // R8
    msb_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        (!rst && code[1]) |=> (code[2] != $past(code[2])));

    // R8
    msb_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!rst && !code[1]) |=> $stable(code[2]));

endmodule

bind seq6_gen seq6_gen_chk u_chk (
    .clk  (clk),
    .rst  (rst),
    .code (code_o)
);

// File: tb/tb_seq6_gen.sv
module tb_seq6_gen;

    localparam int CLK_PERIOD = 10;

    logic       clk;
    logic       rst;
    logic [2:0] code_o;

    int n_checks;
    int n_fail;

    logic [2:0] ref_seq [6];

    seq6_gen dut (
        .clk    (clk),
        .rst    (rst),
        .code_o (code_o)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: code_o=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // one rising edge, then sample after the falling edge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        #1;
        check("R1 reset state", code_o, 3'b011);
        rst = 1'b0;
    endtask

    task automatic t_two_cycles();
        logic [2:0] prev;
        for (int i = 1; i <= 12; i++) begin
            prev = code_o;
            step();
            check("R2 successor", code_o, ref_seq[i % 6]);
            check("R8 msb toggle rule", {code_o[2], 2'b00},
                  {(prev[1] ? ~prev[2] : prev[2]), 2'b00});
            if (i % 6 == 0) check("R3 back to reset code", code_o, 3'b011);
        end
    endtask

    task automatic t_stable();
        logic [2:0] early;
        for (int i = 0; i < 6; i++) begin
            step();
            early = code_o;
            #(CLK_PERIOD/2 - 3);
            check("R4 steady between edges", code_o, early);
        end
    endtask

    task automatic t_reset_mid();
        step();
        step();
        rst = 1'b1;
        step();
        check("R1 reset overrides sequencing", code_o, 3'b011);
        rst = 1'b0;
        step();
        check("R2 restart after reset", code_o, 3'b111);
    endtask

    task automatic inject(input logic [2:0] val);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        force dut.regs_q = val;
        #1;
        release dut.regs_q;
        #1;
    endtask

    task automatic t_unused_000();
        inject(3'b000);
        check("R7 injected code visible", code_o, 3'b000);
        step();
        check("R5 000 recovers", code_o, 3'b010);
        step();
        check("R7 follows loop after recovery", code_o, 3'b100);
    endtask

    task automatic t_unused_101();
        inject(3'b101);
        check("R7 injected code visible", code_o, 3'b101);
        step();
        check("R6 101 recovers", code_o, 3'b110);
        step();
        check("R7 follows loop after recovery", code_o, 3'b011);
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        n_checks = 0;
        n_fail   = 0;
        ref_seq[0] = 3'b011;
        ref_seq[1] = 3'b111;
        ref_seq[2] = 3'b001;
        ref_seq[3] = 3'b010;
        ref_seq[4] = 3'b100;
        ref_seq[5] = 3'b110;
        rst = 1'b1;

        t_reset();
        t_two_cycles();
        t_stable();
        t_reset_mid();
        t_unused_000();
        t_unused_101();
        t_reset();

        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule